// File: doc/BRIEF.md
# Programmable Square-Wave Output Generator

This block drives one open-drain output pin from an 8-bit control register. With the wave enabled, the pin carries a 50% duty square wave at 1 Hz, 4.096 kHz, 8.192 kHz or 32.768 kHz. All four rates come from taps of one shared binary divider, so the rates stay in phase with each other. With the wave disabled, the pin holds a static level taken from a control bit. The pin is modelled as an output-enable. Asserting the enable pulls the line low. Releasing it lets the external pull-up take the line high.

The divider advances on `tick_i`, a one-cycle enable that the surrounding logic pulses twice per 32.768 kHz period. The divider is `DIV_W` bits wide, so one wrap of the divider is one second. The block also exports `sec_tick_o`, a strobe for the timekeeping logic. It pulses in the same cycle that the 1 Hz wave falls, so time advances exactly on that edge. A register write takes effect on the pin at the same clock edge that loads the register.

Top module: `sqw_gen`

## Requirements
- R1: The control register keeps only bit 7 (static level), bit 4 (wave enable) and bits 1:0 (rate code). A write loads these bits, and `ctrl_rdata_o` returns them with every other bit at 0.
- R2: After reset the register reads 0x03: static level 0, wave disabled, rate code 11. The divider is at zero, `sqw_oe_o` is 1 and `sec_tick_o` is 0.
- R3: While the wave enable is 0, the pin level equals the static-level bit, so `sqw_oe_o` is its inverse. Ticks and the rate code have no effect on the pin.
- R4: Rate code 11 gives 32.768 kHz: the pin level is divider bit 0, so it changes on every tick.
- R5: Rate code 10 gives 8.192 kHz: the pin level is divider bit 2, so it changes every 4 ticks.
- R6: Rate code 01 gives 4.096 kHz: the pin level is divider bit 3, so it changes every 8 ticks.
- R7: Rate code 00 gives 1 Hz: the pin level is divider bit `DIV_W-1`, high for half of the `2^DIV_W` ticks and low for the other half.
- R8: `sec_tick_o` pulses for exactly one cycle when the divider wraps, that is, when the 1 Hz wave falls. The pulse occurs in the same cycle the 1 Hz pin goes low, and it occurs whatever the wave enable is.
- R9: A change of the rate code or the enable applies at the edge that writes it. The divider is not reset, so the new tap continues from the running count.
- R10: The divider and the pin change only on cycles with `tick_i` high or on register writes.
- R11: A high pin level is output as `sqw_oe_o` = 0 (released), and a low pin level as `sqw_oe_o` = 1 (pull low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Half-period time-base enable (65.536 kHz rate) |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register contents, unused bits 0 |
| sqw_oe_o | output | 1 | Open-drain enable, 1 pulls the pin low |
| sec_tick_o | output | 1 | One-cycle strobe on the falling edge of the 1 Hz wave |

## Verification
Every result is registered once. The register contents, the pin enable and the seconds strobe all change at the clock edge that takes the write or the tick, so each of them is due one edge after the stimulus. The bench applies each stimulus just after an edge and samples 1 ns after the following edge. It then compares against a tick count it keeps itself. This check is made on every cycle of the rate runs, across both 1 Hz wraps and across the rate switches made mid-count.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    RATE_1HZ = 2'b00,
    RATE_4K  = 2'b01,
    RATE_8K  = 2'b10,
    RATE_32K = 2'b11
  } rate_e;

  // bit order fixed: decoded by the register read path
  typedef struct packed {
    logic       lvl;      // 7: static level
    logic [1:0] rsv_hi;   // 6:5
    logic       wave_en;  // 4
    logic [1:0] rsv_lo;   // 3:2
    rate_e      rate;     // 1:0
  } ctrl_t;

  localparam logic [7:0] CTRL_MASK  = 8'h93;
  localparam logic [7:0] CTRL_RESET = 8'h03;

  // divider tap per rate; the 1 Hz tap is the MSB
  localparam int TAP_32K = 0;
  localparam int TAP_8K  = 2;
  localparam int TAP_4K  = 3;

endpackage

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
  import sqw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      ctrl_q_o,
  output ctrl_t      ctrl_nxt_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_nxt;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (we_i) ctrl_nxt = ctrl_t'(wdata_i & CTRL_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= ctrl_t'(CTRL_RESET);
    else         ctrl_q <= ctrl_nxt;
  end

  assign ctrl_q_o   = ctrl_q;
  assign ctrl_nxt_o = ctrl_nxt;

  p_rsv_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.rsv_hi == 2'b00) && (ctrl_q.rsv_lo == 2'b00));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [DIV_W-1:0] cnt_nxt_o,
  output logic             sec_tick_o
);

  localparam logic [DIV_W-1:0] CNT_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic             sec_q;

  assign cnt_nxt = tick_i ? cnt_q + CNT_ONE : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sec_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      sec_q <= tick_i && (&cnt_q);  // wrap = 1 Hz falling edge
    end
  end

  assign cnt_nxt_o  = cnt_nxt;
  assign sec_tick_o = sec_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));

  p_sec_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> !cnt_q[DIV_W-1] && $past(cnt_q[DIV_W-1]));

  p_sec_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

endmodule

// File: rtl/sqw_out_sel.sv
module sqw_out_sel
  import sqw_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] cnt_nxt_i,
  input  ctrl_t            ctrl_nxt_i,
  output logic             oe_o
);

  localparam int TAP_1HZ = DIV_W - 1;

  logic wave_lvl;
  logic pin_lvl;
  logic oe_q;

  always_comb begin
    unique case (ctrl_nxt_i.rate)
      RATE_1HZ: wave_lvl = cnt_nxt_i[TAP_1HZ];
      RATE_4K:  wave_lvl = cnt_nxt_i[TAP_4K];
      RATE_8K:  wave_lvl = cnt_nxt_i[TAP_8K];
      default:  wave_lvl = cnt_nxt_i[TAP_32K];
    endcase
    pin_lvl = ctrl_nxt_i.wave_en ? wave_lvl : ctrl_nxt_i.lvl;
  end

  // open drain: drive low = enable asserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b1;
    else         oe_q <= ~pin_lvl;
  end

  assign oe_o = oe_q;

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
  import sqw_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic [7:0] ctrl_rdata_o,
  output logic       sqw_oe_o,
  output logic       sec_tick_o
);

  ctrl_t            ctrl_q;
  ctrl_t            ctrl_nxt;
  logic [DIV_W-1:0] cnt_nxt;

  sqw_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .ctrl_q_o   (ctrl_q),
    .ctrl_nxt_o (ctrl_nxt)
  );

  sqw_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cnt_nxt_o  (cnt_nxt),
    .sec_tick_o (sec_tick_o)
  );

  sqw_out_sel #(.DIV_W(DIV_W)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_nxt_i  (cnt_nxt),
    .ctrl_nxt_i (ctrl_nxt),
    .oe_o       (sqw_oe_o)
  );

  assign ctrl_rdata_o = ctrl_q;

  p_static_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.wave_en |-> sqw_oe_o == !ctrl_q.lvl);

  p_32k_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.wave_en && ctrl_q.rate == RATE_32K && $past(tick_i) &&
     $past(ctrl_q.wave_en) && $past(ctrl_q.rate) == RATE_32K)
    |-> sqw_oe_o != $past(sqw_oe_o));

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && !$past(ctrl_we_i)) |-> $stable(sqw_oe_o));

endmodule

// File: tb/tb_sqw_gen.sv
module tb_sqw_gen;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = 8'h00;
  logic [7:0] ctrl_rdata_o;
  logic       sqw_oe_o;
  logic       sec_tick_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [15:0] cnt_m = '0;  // bench tick count
  bit          sec_exp = 1'b0;

  always #5 clk_i = ~clk_i;

  sqw_gen dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock with optional tick; sample 1 ns after the edge
  task automatic cyc(input bit t);
    tick_i = t;
    @(posedge clk_i); #1;
    tick_i = 1'b0;
    sec_exp = t && (cnt_m == 16'hFFFF);
    if (t) cnt_m = cnt_m + 16'd1;
  endtask

  task automatic wr(input logic [7:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(posedge clk_i); #1;
    ctrl_we_i = 1'b0;
    sec_exp = 1'b0;
  endtask

  function automatic logic exp_oe(input int sh);
    return ~cnt_m[sh];
  endfunction

  task automatic t_reset();
    chk("R2 rdata", ctrl_rdata_o, 8'h03);
    chk("R2 R11 oe low", sqw_oe_o, 1'b1);
    chk("R2 sec", sec_tick_o, 1'b0);
  endtask

  task automatic t_regs();
    wr(8'hFF); chk("R1 mask", ctrl_rdata_o, 8'h93);
    wr(8'h6C); chk("R1 rsv only", ctrl_rdata_o, 8'h00);
    wr(8'h91); chk("R1 fields", ctrl_rdata_o, 8'h91);
  endtask

  task automatic t_static();
    wr(8'h80); chk("R3 R11 high released", sqw_oe_o, 1'b0);
    for (int i = 0; i < 20; i++) begin
      cyc(1); chk("R3 ticks ignored", sqw_oe_o, 1'b0);
    end
    wr(8'h83); chk("R3 rate ignored", sqw_oe_o, 1'b0);
    cyc(1); chk("R3 rate ignored tick", sqw_oe_o, 1'b0);
    wr(8'h03); chk("R3 R11 low asserted", sqw_oe_o, 1'b1);
    for (int i = 0; i < 5; i++) begin
      cyc(1); chk("R3 low held", sqw_oe_o, 1'b1);
    end
  endtask

  task automatic t_rate(input logic [1:0] rs, input int sh, input string req);
    wr({6'b000100, rs});
    chk({req, " R9 immediate"}, sqw_oe_o, exp_oe(sh));
    for (int i = 0; i < 40; i++) begin
      cyc(1); chk(req, sqw_oe_o, exp_oe(sh));
    end
  endtask

  task automatic t_no_tick();
    wr(8'h13);
    for (int i = 0; i < 6; i++) begin
      cyc(0); chk("R10 no tick", sqw_oe_o, exp_oe(0));
    end
    cyc(1); chk("R10 tick resumes", sqw_oe_o, exp_oe(0));
  endtask

  task automatic t_wrap(input logic [7:0] v, input string req);
    bit seen = 1'b0;
    wr(v);
    while (!seen) begin
      cyc(1);
      if (v[4]) chk({req, " R7 1Hz level"}, sqw_oe_o, exp_oe(15));
      else      chk({req, " R3 static"}, sqw_oe_o, !v[7]);
      chk({req, " R8 strobe"}, sec_tick_o, sec_exp);
      if (sec_exp) begin
        seen = 1'b1;
        if (v[4]) chk("R8 R7 falls with strobe", sqw_oe_o, 1'b1);
      end
    end
    cyc(0); chk("R8 one cycle", sec_tick_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_regs();
    t_static();
    t_rate(2'b11, 0, "R4 32k");
    t_rate(2'b10, 2, "R5 8k");
    t_rate(2'b01, 3, "R6 4k");
    t_rate(2'b11, 0, "R9 back to 32k");
    t_no_tick();
    t_wrap(8'h10, "wave on");
    t_wrap(8'h80, "wave off");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

endmodule